// File: doc/BRIEF.md
# Luma Sync, Blank and Pedestal Inserter

This block sits on the luma path of a digital video encoder. It takes 8-bit interpolated luma samples at the output sample rate and the line timing (a sync-tip window, a blanking window and the current line number). From these it builds a 10-bit luma / composite-base code. It puts in sync tips and the blanking level. On the lines where it applies, it adds a 7.5 IRE set-up pedestal and rescales active luma so that peak white stays where it was. Transitions into and out of sync and blanking are blended over a fixed number of samples with coefficients from a small table. They are not hard steps.

Control inputs can turn off each element of the output on its own. One removes sync from the video output while a separate composite sync output keeps running. Another forces the picture to black and keeps sync. A third delays luma by one extra sample to line it up with chroma. A fourth replaces the picture with a staircase ramp for measurements. The format input selects either 525-line or 625-line levels.

Top module: `luma_sync_inserter`

## Requirements
- R1: While reset is held, and on release, luma_o equals 240 and csync_o equals 0.
- R2: Once settled, a sync window (sync_i=1, blank_i=1) gives code 16 in both formats. Blanking without sync gives 240 when pal_i=0 and 252 when pal_i=1.
- R3: In active video (blank_i=0, sync_i=0) the luma is first clamped to 16..235. The output is then black + (((Y-16)*G)>>8). Black and G are 240/655 for pal_i=0, 252/641 for pal_i=1, and 282/606 on pedestal lines. The input-to-output latency is 2 samples.
- R4: The pedestal applies only when ped_en_i=1, pal_i=0 and line_i is in 23..262 or 286..525. On any other line, or with pal_i=1, ped_en_i has no effect.
- R5: Entering and leaving sync is ramped over STEPS=4 samples with blend coefficient k*256/4 at step k. From a settled 240 blank with pal_i=0, the samples after sync_i rises are 240, 184, 128, 72, 16. Once blanking has settled, the code changes by no more than 64 per sample.
- R6: With sync_dis_i=1, sync is kept out of luma_o, which stays at blank level or above. csync_o still equals sync_i delayed by 2 samples.
- R7: With luma_dis_i=1, active video outputs the black level that applies (R3) whatever Y is, and sync tips are still produced.
- R8: With luma_dly_i=1, luma reaches the output 3 samples after entering instead of 2. Timing is not delayed.
- R9: With ramp_en_i=1, Y is replaced by a counter. The counter clears while blank_i=1, adds 1 on each sample with blank_i=0 and saturates at 255. The N-th sample after blank_i falls shows the mapped value of count N-1.
- R10: luma_o always lies within 16..800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| luma_i | input | 8 | Interpolated luma sample |
| sync_i | input | 1 | Sync-tip window |
| blank_i | input | 1 | Blanking window |
| line_i | input | 10 | Current line number |
| pal_i | input | 1 | 0: 525-line levels, 1: 625-line levels |
| ped_en_i | input | 1 | Pedestal enable |
| sync_dis_i | input | 1 | Keep sync out of luma_o |
| luma_dis_i | input | 1 | Force active video to black |
| luma_dly_i | input | 1 | One extra sample of luma delay |
| ramp_en_i | input | 1 | Replace picture with test ramp |
| luma_o | output | 10 | Luma / composite-base code |
| csync_o | output | 1 | Composite sync, unaffected by sync_dis_i |

## Verification
On every cycle the assertions check four things: the output code range, the per-sample slew bound once blanking has settled, the two-sample alignment of csync_o with sync_i, and the level floors or ceilings that hold while sync or luma disable has been held. The bench scenarios are needed for everything that depends on exact values. That covers the exact scaled active levels, the pedestal line boundaries, the exact ramp coefficients, the extra luma delay against timing and the values of the test ramp.

// File: rtl/luma_ins_pkg.sv
package luma_ins_pkg;
  localparam int YW   = 8;
  localparam int LW   = 10;
  localparam int LNW  = 10;
  localparam int CW   = 9;

  localparam logic [LW-1:0] TIP_C       = 10'd16;
  localparam logic [LW-1:0] BLANK_525_C = 10'd240;
  localparam logic [LW-1:0] BLANK_625_C = 10'd252;
  localparam logic [LW-1:0] BLACK_PED_C = 10'd282;
  localparam logic [LW-1:0] WHITE_C     = 10'd800;
  localparam logic [9:0]    GAIN_525_C  = 10'd655;
  localparam logic [9:0]    GAIN_625_C  = 10'd641;
  localparam logic [9:0]    GAIN_PED_C  = 10'd606;
  localparam logic [YW-1:0] Y_MIN_C     = 8'd16;
  localparam logic [YW-1:0] Y_MAX_C     = 8'd235;

  typedef struct packed {
    logic [LW-1:0] blank;
    logic [LW-1:0] black;
    logic [9:0]    gain;
  } lvl_t;

  function automatic lvl_t pick_levels(input logic pal, input logic ped_line);
    lvl_t l;
    if (pal) begin
      l.blank = BLANK_625_C; l.black = BLANK_625_C; l.gain = GAIN_625_C;
    end else if (ped_line) begin
      l.blank = BLANK_525_C; l.black = BLACK_PED_C; l.gain = GAIN_PED_C;
    end else begin
      l.blank = BLANK_525_C; l.black = BLANK_525_C; l.gain = GAIN_525_C;
    end
    return l;
  endfunction
endpackage

// File: rtl/lins_edge_shaper.sv
module lins_edge_shaper #(
  parameter int STEPS = 4,
  parameter int CW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  output logic [CW-1:0] coef_o
);
  localparam int PW = $clog2(STEPS + 1);
  localparam logic [PW-1:0] TOP = PW'(STEPS);

  logic [PW-1:0] phase_q;
  logic [CW-1:0] rom [STEPS+1];

  // monotonic blend table, 0 .. 256
  for (genvar k = 0; k <= STEPS; k++) begin : g_rom
    assign rom[k] = CW'((k * 256) / STEPS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       phase_q <= '0;
    else if (act_i && phase_q != TOP)  phase_q <= phase_q + 1'b1;
    else if (!act_i && phase_q != '0)  phase_q <= phase_q - 1'b1;
  end

  assign coef_o = rom[phase_q];
endmodule

// File: rtl/lins_luma_front.sv
module lins_luma_front #(
  parameter int YW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [YW-1:0] luma_i,
  input  logic          blank_i,
  input  logic          dly_en_i,
  input  logic          ramp_en_i,
  output logic [YW-1:0] y_o
);
  logic [YW-1:0] pipe_q [DEPTH];
  logic [YW-1:0] ramp_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_pipe
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= luma_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ramp_q <= '0;
    else if (blank_i)        ramp_q <= '0;
    else if (ramp_q != '1)   ramp_q <= ramp_q + 1'b1;
  end

  always_comb begin
    if (ramp_en_i)     y_o = ramp_q;
    else if (dly_en_i) y_o = pipe_q[DEPTH-1];
    else               y_o = pipe_q[0];
  end
endmodule

// File: rtl/lins_level_map.sv
module lins_level_map
  import luma_ins_pkg::*;
#(
  parameter int PED_A_LO = 23,
  parameter int PED_A_HI = 262,
  parameter int PED_B_LO = 286,
  parameter int PED_B_HI = 525
) (
  input  logic [YW-1:0]  y_i,
  input  logic [LNW-1:0] line_i,
  input  logic           pal_i,
  input  logic           ped_en_i,
  input  logic           luma_dis_i,
  output logic [LW-1:0]  blank_o,
  output logic [LW-1:0]  act_o
);
  logic          ped_line;
  lvl_t          lv;
  logic [YW-1:0] yc;
  logic [19:0]   prod;

  always_comb begin
    ped_line = ped_en_i && !pal_i &&
               ((int'(line_i) >= PED_A_LO && int'(line_i) <= PED_A_HI) ||
                (int'(line_i) >= PED_B_LO && int'(line_i) <= PED_B_HI));
    lv = pick_levels(pal_i, ped_line);
    if (y_i < Y_MIN_C)      yc = Y_MIN_C;
    else if (y_i > Y_MAX_C) yc = Y_MAX_C;
    else                    yc = y_i;
    prod = 20'(yc - Y_MIN_C) * 20'(lv.gain);
    blank_o = lv.blank;
    act_o   = luma_dis_i ? lv.black : lv.black + LW'(prod >> 8);
  end
endmodule

// File: rtl/lins_compose.sv
module lins_compose
  import luma_ins_pkg::*;
(
  input  logic [LW-1:0] blank_i,
  input  logic [LW-1:0] act_i,
  input  logic [CW-1:0] bcoef_i,
  input  logic [CW-1:0] scoef_i,
  output logic [LW-1:0] level_o
);
  logic [LW-1:0] v;
  logic [19:0]   bprod, sprod;

  always_comb begin
    bprod   = 20'(act_i - blank_i) * 20'(bcoef_i);
    v       = blank_i + LW'(bprod >> 8);
    sprod   = 20'(v - TIP_C) * 20'(scoef_i);
    level_o = v - LW'(sprod >> 8);
  end
endmodule

// File: rtl/luma_sync_inserter.sv
module luma_sync_inserter
  import luma_ins_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int DEPTH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [7:0]     luma_i,
  input  logic           sync_i,
  input  logic           blank_i,
  input  logic [9:0]     line_i,
  input  logic           pal_i,
  input  logic           ped_en_i,
  input  logic           sync_dis_i,
  input  logic           luma_dis_i,
  input  logic           luma_dly_i,
  input  logic           ramp_en_i,
  output logic [9:0]     luma_o,
  output logic           csync_o
);
  logic [YW-1:0] y_s;
  logic [CW-1:0] bcoef, scoef;
  logic [LW-1:0] blank_lvl, act_lvl, level;
  logic [LW-1:0] out_q;
  logic [1:0]    csync_q;

  lins_luma_front #(.YW(YW), .DEPTH(DEPTH)) u_front (
    .clk_i, .rst_ni, .luma_i, .blank_i,
    .dly_en_i(luma_dly_i), .ramp_en_i, .y_o(y_s)
  );

  lins_edge_shaper #(.STEPS(STEPS), .CW(CW)) u_blank_shp (
    .clk_i, .rst_ni, .act_i(!blank_i), .coef_o(bcoef)
  );

  lins_edge_shaper #(.STEPS(STEPS), .CW(CW)) u_sync_shp (
    .clk_i, .rst_ni, .act_i(sync_i && !sync_dis_i), .coef_o(scoef)
  );

  lins_level_map u_map (
    .y_i(y_s), .line_i, .pal_i, .ped_en_i, .luma_dis_i,
    .blank_o(blank_lvl), .act_o(act_lvl)
  );

  lins_compose u_comp (
    .blank_i(blank_lvl), .act_i(act_lvl),
    .bcoef_i(bcoef), .scoef_i(scoef), .level_o(level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= BLANK_525_C;
      csync_q <= '0;
    end else begin
      out_q   <= level;
      csync_q <= {csync_q[0], sync_i};
    end
  end

  assign luma_o  = out_q;
  assign csync_o = csync_q[1];
endmodule

// File: rtl/lins_checker.sv
module lins_checker #(
  parameter int STEPS = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_i,
  input logic       blank_i,
  input logic       sync_dis_i,
  input logic       luma_dis_i,
  input logic [9:0] luma_o,
  input logic       csync_o
);
  logic [7:0] since_rst, blank_run, sdis_run, ldis_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0; blank_run <= '0; sdis_run <= '0; ldis_run <= '0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      blank_run <= !blank_i    ? '0 : (blank_run == '1 ? blank_run : blank_run + 1'b1);
      sdis_run  <= !sync_dis_i ? '0 : (sdis_run  == '1 ? sdis_run  : sdis_run  + 1'b1);
      ldis_run  <= !luma_dis_i ? '0 : (ldis_run  == '1 ? ldis_run  : ldis_run  + 1'b1);
    end
  end

  a_r10_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    luma_o >= 10'd16 && luma_o <= 10'd800);

  a_r5_slew: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(blank_run) >= STEPS + 4) |->
      (11'(luma_o) <= 11'($past(luma_o)) + 11'd64 &&
       11'($past(luma_o)) <= 11'(luma_o) + 11'd64));

  a_r6_csync_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 8'd3) |-> (csync_o == $past(sync_i, 2)));

  a_r6_no_sync_when_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sdis_run) >= STEPS + 3) |-> (luma_o >= 10'd240));

  a_r7_black_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldis_run >= 8'd3) |-> (luma_o <= 10'd282));
endmodule

bind luma_sync_inserter lins_checker #(.STEPS(STEPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .blank_i(blank_i),
  .sync_dis_i(sync_dis_i), .luma_dis_i(luma_dis_i),
  .luma_o(luma_o), .csync_o(csync_o)
);

// File: tb/luma_sync_inserter_tb.sv
module luma_sync_inserter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] luma_i = '0;
  logic       sync_i = 1'b0, blank_i = 1'b1;
  logic [9:0] line_i = '0;
  logic       pal_i = 1'b0, ped_en_i = 1'b0, sync_dis_i = 1'b0;
  logic       luma_dis_i = 1'b0, luma_dly_i = 1'b0, ramp_en_i = 1'b0;
  logic [9:0] luma_o;
  logic       csync_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  luma_sync_inserter dut_i (
    .clk_i(clk), .rst_ni, .luma_i, .sync_i, .blank_i, .line_i, .pal_i,
    .ped_en_i, .sync_dis_i, .luma_dis_i, .luma_dly_i, .ramp_en_i,
    .luma_o, .csync_o
  );

  typedef struct packed {
    logic       pal;
    logic       ped;
    logic [9:0] line;
    logic       sync;
    logic       blank;
    logic [7:0] y;
    logic       ldis;
    logic       sdis;
    logic [9:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,10'd100,1'b1,1'b1,8'd126,1'b0,1'b0,10'd16 ,4'd2}, // R2 tip 525
    '{1'b1,1'b0,10'd100,1'b1,1'b1,8'd126,1'b0,1'b0,10'd16 ,4'd2}, // R2 tip 625
    '{1'b0,1'b0,10'd100,1'b0,1'b1,8'd126,1'b0,1'b0,10'd240,4'd2}, // R2 blank 525
    '{1'b1,1'b0,10'd100,1'b0,1'b1,8'd126,1'b0,1'b0,10'd252,4'd2}, // R2 blank 625
    '{1'b0,1'b0,10'd100,1'b0,1'b0,8'd126,1'b0,1'b0,10'd521,4'd3}, // R3 mid
    '{1'b0,1'b0,10'd100,1'b0,1'b0,8'd235,1'b0,1'b0,10'd800,4'd3}, // R3 white
    '{1'b0,1'b0,10'd100,1'b0,1'b0,8'd250,1'b0,1'b0,10'd800,4'd3}, // R3 clamp hi
    '{1'b0,1'b0,10'd100,1'b0,1'b0,8'd5  ,1'b0,1'b0,10'd240,4'd3}, // R3 clamp lo
    '{1'b1,1'b0,10'd100,1'b0,1'b0,8'd126,1'b0,1'b0,10'd527,4'd3}, // R3 625
    '{1'b0,1'b1,10'd100,1'b0,1'b0,8'd126,1'b0,1'b0,10'd542,4'd3}, // R3 ped
    '{1'b0,1'b1,10'd100,1'b0,1'b0,8'd235,1'b0,1'b0,10'd800,4'd3}, // R3 ped white
    '{1'b0,1'b1,10'd10 ,1'b0,1'b0,8'd126,1'b0,1'b0,10'd521,4'd4}, // R4 off line
    '{1'b0,1'b1,10'd22 ,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd240,4'd4}, // R4
    '{1'b0,1'b1,10'd23 ,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd282,4'd4}, // R4
    '{1'b0,1'b1,10'd262,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd282,4'd4}, // R4
    '{1'b0,1'b1,10'd263,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd240,4'd4}, // R4
    '{1'b0,1'b1,10'd285,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd240,4'd4}, // R4
    '{1'b0,1'b1,10'd286,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd282,4'd4}, // R4
    '{1'b0,1'b1,10'd525,1'b0,1'b0,8'd16 ,1'b0,1'b0,10'd282,4'd4}, // R4
    '{1'b1,1'b1,10'd100,1'b0,1'b0,8'd126,1'b0,1'b0,10'd527,4'd4}, // R4 625
    '{1'b0,1'b1,10'd100,1'b0,1'b0,8'd200,1'b1,1'b0,10'd282,4'd7}, // R7
    '{1'b0,1'b0,10'd100,1'b1,1'b1,8'd126,1'b0,1'b1,10'd240,4'd6}  // R6
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: luma_o actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: csync_o actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", luma_o, 10'd240);
    check_bit("R1", csync_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    tick();
    check("R1", luma_o, 10'd240);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pal_i = VECS[i].pal; ped_en_i = VECS[i].ped; line_i = VECS[i].line;
      sync_i = VECS[i].sync; blank_i = VECS[i].blank; luma_i = VECS[i].y;
      luma_dis_i = VECS[i].ldis; sync_dis_i = VECS[i].sdis;
      repeat (10) tick();
      check($sformatf("R%0d vec%0d", VECS[i].req, i), luma_o, VECS[i].exp);
    end

    // R6 csync keeps running with sync disabled
    check_bit("R6", csync_o, 1'b1);
    @(negedge clk); sync_i = 1'b0; sync_dis_i = 1'b0;
    repeat (10) tick();

    // R5 sync edge ramp from settled blank, R6 csync latency
    @(negedge clk); pal_i = 0; ped_en_i = 0; blank_i = 1; sync_i = 0;
    repeat (10) tick();
    @(negedge clk); sync_i = 1'b1;
    tick(); check("R5 step0", luma_o, 10'd240); check_bit("R6 lat1", csync_o, 1'b0);
    tick(); check("R5 step1", luma_o, 10'd184); check_bit("R6 lat2", csync_o, 1'b1);
    tick(); check("R5 step2", luma_o, 10'd128);
    tick(); check("R5 step3", luma_o, 10'd72);
    tick(); check("R5 step4", luma_o, 10'd16);
    // R7 sync still present with luma disabled
    @(negedge clk); luma_dis_i = 1'b1;
    repeat (6) tick(); check("R7 sync kept", luma_o, 10'd16);
    @(negedge clk); sync_i = 1'b0; luma_dis_i = 1'b0;
    repeat (8) tick();

    // R8 luma delay, without and with
    @(negedge clk); blank_i = 0; luma_i = 8'd16; luma_dly_i = 0;
    repeat (10) tick();
    @(negedge clk); luma_i = 8'd235;
    tick(); check("R8 nodly e1", luma_o, 10'd240);
    tick(); check("R8 nodly e2", luma_o, 10'd800);
    @(negedge clk); luma_i = 8'd16; luma_dly_i = 1;
    repeat (10) tick();
    @(negedge clk); luma_i = 8'd235;
    tick(); check("R8 dly e1", luma_o, 10'd240);
    tick(); check("R8 dly e2", luma_o, 10'd240);
    tick(); check("R8 dly e3", luma_o, 10'd800);
    @(negedge clk); luma_dly_i = 0;

    // R9 test ramp
    @(negedge clk); blank_i = 1; ramp_en_i = 1;
    repeat (10) tick();
    @(negedge clk); blank_i = 0;
    repeat (20) tick();
    check("R9 cnt19", luma_o, 10'd247);
    tick();
    check("R9 cnt20", luma_o, 10'd250);
    @(negedge clk); ramp_en_i = 0; blank_i = 1;
    repeat (10) tick();

    report();
  end
endmodule